// File: doc/BRIEF.md
# Constant Reciprocal Divider

This block divides an unsigned W-bit dividend by a divisor D that is fixed when the design is elaborated. It contains no iterative divider. Constant functions derive a fixed-point reciprocal and a right-shift count from W and D. Each operand is then multiplied by that reciprocal, the upper W bits of the product are kept, and the result is shifted. The quotient is always the exact floor of n/D.

Generate branches choose one of four datapaths from D:
- a plain right shift, when D is a power of two (this includes D = 1);
- a single compare, when D is above half the dividend range;
- a multiply-high, when the reciprocal fits in W bits;
- a corrected multiply-high, which stands in for a W+1-bit multiplier without overflowing the W-bit adder.

An optional remainder output is also produced.

Operands enter through a valid/ready handshake and results leave through a second valid/ready handshake. The pipeline has two register stages. When the consumer stalls, the whole pipeline stalls with it.

Top module: `recip_divider`

## Requirements
- R1: A dividend accepted on a clock edge (in_valid and in_ready both high) appears on out_valid/out_quot exactly two clock edges later when out_ready stays high. Results leave in acceptance order, with none lost and none repeated.
- R2: When HAS_REM is 1, out_rem equals n mod D and is always below D.
- R3: For D a power of two, out_quot is n shifted right by log2(D), and out_rem is n with all bits at and above position log2(D) cleared. D = 1 returns the dividend unchanged with remainder 0.
- R4: For D greater than 2^(W-1), out_quot is 1 when n >= D and 0 otherwise.
- R5: Divisors whose reciprocal needs W+1 bits (for W = 32, D = 7) give floor(n/D) for every n, including n = 2^W-1. The internal difference of dividend and product-high never borrows.
- R6: Divisors whose reciprocal fits in W bits (for W = 32, D = 5 and D = 10) give floor(n/D) for every n.
- R7: While out_valid is high and out_ready is low, in_ready is low, and out_valid, out_quot and out_rem hold their values on the next edge.
- R8: After synchronous reset, out_valid is 0 and in_ready is 1.
- R9: The reciprocal for W = 64, D = 5 is 0xCCCCCCCCCCCCCCCD with post-shift 2. For W = 32, D = 10 it is 0xCCCCCCCD with post-shift 3. For W = 32, D = 7 it needs bit 32 set.
- R10: out_quot never exceeds floor((2^W-1)/D). For n = 2^W-1 it equals that bound.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Dividend offered |
| in_ready | output | 1 | Pipeline can take a dividend this cycle |
| in_dividend | input | W | Unsigned dividend |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_quot | output | W | floor(n/D) |
| out_rem | output | W | n mod D (zero when HAS_REM is 0) |

## Verification
A quotient and remainder become visible two rising edges after the edge that accepted the dividend. Any cycle with out_ready low pushes that point back by one cycle per stall.

The bench drives inputs and samples outputs only at falling edges. It predicts each handshake from the settled values just before the next rising edge. It keeps a queue of accepted dividends and pops the queue on every predicted output transfer.

During an initial stretch in which out_ready is held high, the bench also checks that the distance between acceptance and delivery is exactly two cycles.

// File: rtl/recip_div_pkg.sv
package recip_div_pkg;

  typedef enum logic [1:0] {
    PATH_SHIFT  = 2'd0,
    PATH_CMP    = 2'd1,
    PATH_MULHI  = 2'd2,
    PATH_MULEMU = 2'd3
  } path_e;

  typedef struct packed {
    logic [64:0] mult;   // up to W+1 bits of reciprocal
    logic [7:0]  post;   // right shift applied after the multiply-high
  } magic_t;

  function automatic int ceil_log2(longint unsigned d);
    int r;
    longint unsigned v;
    r = 0;
    v = 64'd1;
    while (v < d && r < 64) begin
      v = v << 1;
      r++;
    end
    return r;
  endfunction

  function automatic bit is_pow2(longint unsigned d);
    return (d != 64'd0) && ((d & (d - 64'd1)) == 64'd0);
  endfunction

  // Smallest reciprocal / shift pair that keeps the error below 1/d for
  // every w-bit dividend.
  function automatic magic_t calc_magic(int w, longint unsigned d);
    magic_t      m;
    logic [129:0] base, m_lo, m_hi;
    int          l, sh;
    l    = ceil_log2(d);
    base = 130'd1 << (w + l);
    m_lo = base / 130'(d);
    m_hi = (base + (130'd1 << l)) / 130'(d);
    sh   = l;
    while (sh > 0 && (m_lo >> 1) < (m_hi >> 1)) begin
      m_lo = m_lo >> 1;
      m_hi = m_hi >> 1;
      sh--;
    end
    m.mult = m_hi[64:0];
    m.post = 8'(sh);
    return m;
  endfunction

  function automatic path_e choose_path(int w, longint unsigned d);
    magic_t m;
    if (is_pow2(d)) return PATH_SHIFT;
    if (d > (64'd1 << (w - 1))) return PATH_CMP;
    m = calc_magic(w, d);
    if ((m.mult >> w) != 65'd0) return PATH_MULEMU;
    return PATH_MULHI;
  endfunction

endpackage

// File: rtl/recip_div_mulhi.sv
// Stage 1: registers the dividend together with the upper half of its
// product with the reciprocal.
module recip_div_mulhi #(
  parameter int         W       = 32,
  parameter logic [W-1:0] MULT  = '0,
  parameter bit         USE_MUL = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         in_v,
  input  logic [W-1:0] n,
  output logic         v1,
  output logic [W-1:0] n1,
  output logic [W-1:0] hi1
);

  logic [W-1:0] hi_c;

  generate
    if (USE_MUL) begin : g_mul
      logic [2*W-1:0] prod;
      logic           unused_lo;
      assign prod      = {{W{1'b0}}, n} * {{W{1'b0}}, MULT};
      assign hi_c      = prod[2*W-1:W];
      assign unused_lo = ^prod[W-1:0];
    end else begin : g_nomul
      assign hi_c = '0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      v1  <= 1'b0;
      n1  <= '0;
      hi1 <= '0;
    end else if (en) begin
      v1  <= in_v;
      n1  <= n;
      hi1 <= hi_c;
    end
  end

endmodule

// File: rtl/recip_div_fix.sv
// Stage 2: path-specific correction and shift, then remainder.
module recip_div_fix #(
  parameter int                   W       = 32,
  parameter longint unsigned      D       = 7,
  parameter recip_div_pkg::path_e PATH    = recip_div_pkg::PATH_MULEMU,
  parameter int                   POST    = 3,
  parameter int                   LOG2D   = 3,
  parameter bit                   HAS_REM = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         v1,
  input  logic [W-1:0] n1,
  input  logic [W-1:0] hi1,
  output logic         v2,
  output logic [W-1:0] q2,
  output logic [W-1:0] r2
);

  localparam logic [W-1:0] DW = W'(D);

  logic [W-1:0] q_c;
  logic [W-1:0] r_c;
  logic         unused_in;

  assign unused_in = ^{n1, hi1};

  generate
    if (PATH == recip_div_pkg::PATH_SHIFT) begin : g_shift
      assign q_c = n1 >> LOG2D;
    end else if (PATH == recip_div_pkg::PATH_CMP) begin : g_cmp
      assign q_c = (n1 >= DW) ? W'(1) : '0;
    end else if (PATH == recip_div_pkg::PATH_MULHI) begin : g_mulhi
      assign q_c = hi1 >> POST;
    end else begin : g_emu
      // hi + (n - hi)/2 never exceeds n, so the W-bit add cannot wrap.
      logic [W-1:0] half_gap;
      assign half_gap = (n1 - hi1) >> 1;
      assign q_c      = (hi1 + half_gap) >> (POST - 1);
      AST_EMU_NO_BORROW: assert property (@(posedge clk) disable iff (rst)
        v1 |-> (hi1 <= n1)) else $error("product-high exceeds dividend"); // R5
    end
  endgenerate

  generate
    if (!HAS_REM) begin : g_norem
      assign r_c = '0;
    end else if (PATH == recip_div_pkg::PATH_SHIFT) begin : g_rem_mask
      assign r_c = n1 & (DW - W'(1));
    end else begin : g_rem_sub
      logic [W-1:0] qd;
      assign qd  = q_c * DW;
      assign r_c = n1 - qd;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      v2 <= 1'b0;
      q2 <= '0;
      r2 <= '0;
    end else if (en) begin
      v2 <= v1;
      q2 <= q_c;
      r2 <= r_c;
    end
  end

endmodule

// File: rtl/recip_divider.sv
module recip_divider #(
  parameter int              W       = 32,
  parameter longint unsigned D       = 7,
  parameter bit              HAS_REM = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_dividend,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_quot,
  output logic [W-1:0] out_rem
);

  localparam recip_div_pkg::magic_t MAG   = recip_div_pkg::calc_magic(W, D);
  localparam recip_div_pkg::path_e  PATH  = recip_div_pkg::choose_path(W, D);
  localparam logic [W-1:0]          MULT  = MAG.mult[W-1:0];
  localparam int                    POST  = int'(MAG.post);
  localparam int                    LOG2D = recip_div_pkg::ceil_log2(D);
  localparam bit USE_MUL = (PATH == recip_div_pkg::PATH_MULHI) ||
                           (PATH == recip_div_pkg::PATH_MULEMU);
  localparam logic [W-1:0] DW   = W'(D);
  localparam longint unsigned QMAX64 = ((W == 64) ? 64'hFFFF_FFFF_FFFF_FFFF
                                                  : ((64'd1 << W) - 64'd1)) / D;
  localparam logic [W-1:0] QMAX = W'(QMAX64);

  generate
    if (D == 64'd0 || W < 2 || W > 64 || (W < 64 && D >= (64'd1 << W))) begin : g_bad_cfg
      initial $fatal(1, "recip_divider: divisor must be in 1 .. 2^W-1, W in 2..64");
    end
  endgenerate

  logic         adv;
  logic         v1, v2;
  logic [W-1:0] n1, hi1;

  assign adv      = ~v2 | out_ready;
  assign in_ready = adv;

  recip_div_mulhi #(
    .W       (W),
    .MULT    (MULT),
    .USE_MUL (USE_MUL)
  ) u_mul (
    .clk  (clk),
    .rst  (rst),
    .en   (adv),
    .in_v (in_valid),
    .n    (in_dividend),
    .v1   (v1),
    .n1   (n1),
    .hi1  (hi1)
  );

  recip_div_fix #(
    .W       (W),
    .D       (D),
    .PATH    (PATH),
    .POST    (POST),
    .LOG2D   (LOG2D),
    .HAS_REM (HAS_REM)
  ) u_fix (
    .clk (clk),
    .rst (rst),
    .en  (adv),
    .v1  (v1),
    .n1  (n1),
    .hi1 (hi1),
    .v2  (v2),
    .q2  (out_quot),
    .r2  (out_rem)
  );

  assign out_valid = v2;

  AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready) else $error("input taken during stall"); // R7

  AST_STALL_HOLDS_OUTPUT: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_quot) && $stable(out_rem)))
    else $error("result changed while stalled"); // R7

  AST_QUOT_BOUND: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_quot <= QMAX)) else $error("quotient above range"); // R10

  generate
    if (HAS_REM) begin : g_rem_chk
      AST_REM_BELOW_D: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_rem < DW)) else $error("remainder not below divisor"); // R2
    end
  endgenerate

endmodule

// File: tb/sim_recip_divider.sv
module sim_recip_divider;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int W  = 32;
  localparam int NI = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic         in_valid  = 1'b0;
  logic         out_ready = 1'b0;
  logic [W-1:0] din       = '0;
  logic         ov [NI];
  logic         ir [NI];
  logic [W-1:0] q  [NI];
  logic [W-1:0] r  [NI];

  int nchk  = 0;
  int nfail = 0;
  bit done  = 1'b0;

  recip_divider #(.W(W), .D(64'd7)) u0 (.clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(ir[0]),
    .in_dividend(din), .out_valid(ov[0]), .out_ready(out_ready), .out_quot(q[0]), .out_rem(r[0]));
  recip_divider #(.W(W), .D(64'd5)) u1 (.clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(ir[1]),
    .in_dividend(din), .out_valid(ov[1]), .out_ready(out_ready), .out_quot(q[1]), .out_rem(r[1]));
  recip_divider #(.W(W), .D(64'd10)) u2 (.clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(ir[2]),
    .in_dividend(din), .out_valid(ov[2]), .out_ready(out_ready), .out_quot(q[2]), .out_rem(r[2]));
  recip_divider #(.W(W), .D((64'd1 << 31) + 64'd1)) u3 (.clk(clk), .rst(rst), .in_valid(in_valid),
    .in_ready(ir[3]), .in_dividend(din), .out_valid(ov[3]), .out_ready(out_ready), .out_quot(q[3]),
    .out_rem(r[3]));
  recip_divider #(.W(W), .D(64'd16)) u4 (.clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(ir[4]),
    .in_dividend(din), .out_valid(ov[4]), .out_ready(out_ready), .out_quot(q[4]), .out_rem(r[4]));
  recip_divider #(.W(W), .D(64'd1)) u5 (.clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(ir[5]),
    .in_dividend(din), .out_valid(ov[5]), .out_ready(out_ready), .out_quot(q[5]), .out_rem(r[5]));

  function automatic longint unsigned div_of(int i);
    case (i)
      0:       return 64'd7;
      1:       return 64'd5;
      2:       return 64'd10;
      3:       return (64'd1 << 31) + 64'd1;
      4:       return 64'd16;
      default: return 64'd1;
    endcase
  endfunction

  function automatic string tag_of(int i);
    case (i)
      0:       return "R5";
      1, 2:    return "R6";
      3:       return "R4";
      default: return "R3";
    endcase
  endfunction

  task automatic chk(bit ok, string req, string what, longint unsigned act, longint unsigned exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
  endtask

  initial begin
    logic [W-1:0]         stim [$];
    logic [W-1:0]         pend [$];
    int unsigned          pcyc [$];
    int                   idx, ndir;
    bit                   free_run, prev_stall;
    logic [W-1:0]         prev_q, prev_r, nv;
    int unsigned          st;
    longint unsigned      d, eq, er, k;
    recip_div_pkg::magic_t m;

    void'($urandom(32'd20240611));

    // R9: reciprocal constants
    m = recip_div_pkg::calc_magic(64, 64'd5);
    chk(m.mult == 65'h0_CCCC_CCCC_CCCC_CCCD, "R9", "mult W64 D5", 64'(m.mult), 64'hCCCC_CCCC_CCCC_CCCD);
    chk(m.post == 8'd2, "R9", "post W64 D5", 64'(m.post), 64'd2);
    m = recip_div_pkg::calc_magic(32, 64'd10);
    chk(m.mult == 65'h0_CCCC_CCCD && m.post == 8'd3, "R9", "mult W32 D10", 64'(m.mult), 64'hCCCC_CCCD);
    m = recip_div_pkg::calc_magic(32, 64'd7);
    chk(m.mult[32] == 1'b1, "R9", "bit 32 of W32 D7", 64'(m.mult[32]), 64'd1);

    // directed dividends
    stim.push_back(32'd0);          stim.push_back(32'd1);
    stim.push_back(32'd2);          stim.push_back(32'd3);
    stim.push_back(32'hFFFF_FFFF);  stim.push_back(32'hFFFF_FFFE);
    stim.push_back(32'h8000_0000);  stim.push_back(32'h8000_0001);
    stim.push_back(32'h8000_0002);  stim.push_back(32'h7FFF_FFFF);
    for (int di = 0; di < 5; di++) begin
      d = div_of(di);
      for (int kk = 0; kk < 5; kk++) begin
        case (kk)
          0: k = 64'd1;
          1: k = 64'd2;
          2: k = 64'hFFFF_FFFF / d;
          default: k = 64'($urandom) / d;
        endcase
        stim.push_back(W'(k * d - 64'd1));
        stim.push_back(W'(k * d));
        stim.push_back(W'(k * d + 64'd1));
      end
    end
    ndir = stim.size();
    for (int i = 0; i < 2500; i++) stim.push_back($urandom);

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R8: reset state
    for (int i = 0; i < NI; i++) begin
      chk(ov[i] == 1'b0, "R8", "out_valid after reset", 64'(ov[i]), 64'd0);
      chk(ir[i] == 1'b1, "R8", "in_ready after reset", 64'(ir[i]), 64'd1);
    end

    idx = 0;
    prev_stall = 1'b0;
    prev_q = '0;
    prev_r = '0;
    for (int c = 0; c < 60000; c++) begin
      if (idx >= stim.size() && pend.size() == 0) break;
      @(negedge clk);
      if (prev_stall) begin
        chk(ov[0] && q[0] == prev_q && r[0] == prev_r, "R7", "held result", 64'(q[0]), 64'(prev_q));
      end
      free_run = (idx < ndir);
      if (free_run) begin
        in_valid  = 1'b1;
        out_ready = 1'b1;
      end else begin
        in_valid  = (idx < stim.size()) && (($urandom % 4) != 0);
        out_ready = ($urandom % 3) != 0;
      end
      din = in_valid ? stim[idx] : $urandom;
      #1;
      prev_stall = ov[0] && !out_ready;
      prev_q = q[0];
      prev_r = r[0];
      if (prev_stall) chk(ir[0] == 1'b0, "R7", "in_ready during stall", 64'(ir[0]), 64'd0);
      if (ov[0] && out_ready) begin
        if (pend.size() == 0) begin
          chk(1'b0, "R1", "output with nothing pending", 64'd1, 64'd0);
        end else begin
          nv = pend.pop_front();
          st = pcyc.pop_front();
          if (free_run) chk((c - st) == 2, "R1", "latency", 64'(c - st), 64'd2);
          for (int i = 0; i < NI; i++) begin
            d  = div_of(i);
            eq = 64'(nv) / d;
            er = 64'(nv) % d;
            chk(ov[i] == 1'b1, "R1", "out_valid alignment", 64'(ov[i]), 64'd1);
            chk(64'(q[i]) == eq, tag_of(i), "quotient", 64'(q[i]), eq);
            chk(64'(r[i]) == er, "R2", "remainder", 64'(r[i]), er);
            if (nv == '1) chk(64'(q[i]) == 64'hFFFF_FFFF / d, "R10", "max quotient", 64'(q[i]),
                              64'hFFFF_FFFF / d);
          end
        end
      end
      if (in_valid && ir[0]) begin
        pend.push_back(din);
        pcyc.push_back(c);
        idx++;
      end
    end

    @(negedge clk);
    in_valid  = 1'b0;
    out_ready = 1'b1;
    repeat (4) @(negedge clk);
    chk(pend.size() == 0 && idx == stim.size(), "R1", "all results delivered", 64'(pend.size()), 64'd0);
    chk(ov[0] == 1'b0, "R1", "no spurious output", 64'(ov[0]), 64'd0);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL R1 watchdog: actual hung expected completion");
      summary();
      $finish;
    end
  end

endmodule